// File: doc/BRIEF.md
# HDLC Receive Block FIFO Controller

This block sits between an HDLC receiver and a host processor. It holds received bytes in a shared circular buffer that can contain several frames at once. The receiver pushes the data bytes of each frame. When a frame ends, it pushes one extra status byte, marked by a flag, directly after the last data byte.

The controller hands the buffer to the host one block at a time. The host picks the block size with a 2-bit selector. When a full block of data is stored with no status byte inside it, the controller raises a pool-full interrupt. This happens even if the frame is still arriving. When a status byte falls inside the block window, the block is cut short at that byte and a message-end interrupt is raised instead. A running byte count for the frame is reported at each announcement. The host reads the block byte by byte and then issues a release command. The release frees the block's space and lets the controller evaluate the next block.

Top module: `hdlc_rx_blkfifo`

## Requirements
- R1: After reset, both interrupts are low, the byte count is 0 and the overflow flag is 0.
- R2: The block size selector maps 2'b00 to 32 bytes, 2'b01 to 16 bytes, 2'b10 to 8 bytes and 2'b11 to 4 bytes.
- R3: If no block is pending and at least one block-size of bytes is held beyond the block start with no status byte among them, irq_pool_full rises on the next clock edge. This holds whether or not the frame has ended.
- R4: If no block is pending and a status byte lies within the first block-size bytes beyond the block start, irq_msg_end rises instead. The block length is then the offset of that status byte plus one.
- R5: At each announcement, the byte count adds the block length: the block size for pool-full, or the short length including the status byte for message-end. The first block after a message-end block, or after reset, starts the count again from zero.
- R6: At most one interrupt is pending at a time. It stays up, with its block length, until a release command. No new block is evaluated while one is pending.
- R7: A release while a block is pending frees exactly that block's length, drops all of its interrupts, and moves the host read position to the next block's first byte, discarding any unread bytes of the released block. A release with nothing pending has no effect.
- R8: host_data shows the byte at the host read position. A host_rd pulse advances the position only while a block is pending and fewer than its length have been read. Other host_rd pulses are ignored.
- R9: A write while 64 bytes are held is dropped and sets a sticky overflow flag. Fullness is judged before a release in the same cycle takes effect.
- R10: A new block size applies to the next block evaluated after a release. A write and a release in the same cycle both take effect, and the written byte joins the next evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receiver writes one byte this cycle |
| rx_byte | input | 8 | Byte from the receiver |
| rx_is_status | input | 1 | 1 marks the byte as the end-of-frame status byte |
| blk_size_sel | input | 2 | Block size selector (see R2) |
| host_rd | input | 1 | Host consumes the byte on host_data |
| host_release | input | 1 | Host release command for the pending block |
| host_data | output | 8 | Byte at the host read position |
| irq_pool_full | output | 1 | Full block pending |
| irq_msg_end | output | 1 | Short frame-ending block pending |
| rx_byte_count | output | 12 | Bytes of the current frame announced so far |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
Two functions can land in the same cycle: the host's release, which moves the block start forward, and a receiver write, which moves the write position and may carry the status byte. The bench provokes this twice. In the first case, a status byte is pushed in the very cycle a 4-byte pool-full block is released. The next announcement must then be a 1-byte message-end block with the count at 5. In the second case, a status byte is pushed with the buffer full, in the cycle the full block is released. That byte must be dropped, which the bench judges by seeing no further interrupt once the remaining data has been released.

// File: rtl/hrf_pkg.sv
// Shared definitions for the HDLC receive block FIFO.
// Assumes the block size selector is two bits wide and the largest block is 32 bytes.
package hrf_pkg;

    localparam int unsigned MAX_BLK = 32;

    typedef enum logic {
        BLK_POOL = 1'b0,
        BLK_END  = 1'b1
    } blk_kind_t;

    // Block size in bytes for a selector code: 00->32, 01->16, 10->8, 11->4.
    function automatic int unsigned blk_bytes(input logic [1:0] code);
        return MAX_BLK >> code;
    endfunction

endpackage

// File: rtl/hrf_store.sv
// Circular byte store with a status mark per entry.
// Holds the write pointer and the block-start pointer, both one bit wider than
// the address so that a full buffer can be told apart from an empty one.
// Space is freed only through rel_valid/rel_len. A write into a full buffer is
// dropped and sets a sticky overflow flag.
// Assumes DEPTH is a power of two and at least MAX_BLK.
module hrf_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_mark,
    input  logic             rel_valid,
    input  logic [PW-1:0]    rel_len,
    input  logic [PW-1:0]    rd_off,
    output logic [DW-1:0]    rd_data,
    output logic [PW-1:0]    base,
    output logic [PW-1:0]    occ,
    output logic [DEPTH-1:0] marks,
    output logic             ovf
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] bptr;
    logic          full;
    logic [AW-1:0] raddr;

    assign occ   = wptr - bptr;
    assign full  = (occ == PW'(DEPTH));
    assign base  = bptr;
    assign raddr = bptr[AW-1:0] + rd_off[AW-1:0];
    assign rd_data = mem[raddr];

    // Storage array: accepts a byte whenever there is room.
    always_ff @(posedge clk) begin
        if (wr_valid && !full) begin
            mem[wptr[AW-1:0]] <= wr_data;
        end
    end

    // Status marks: one bit per entry, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marks <= '0;
        end else if (wr_valid && !full) begin
            marks[wptr[AW-1:0]] <= wr_mark;
        end
    end

    // Pointers and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            bptr <= '0;
            ovf  <= 1'b0;
        end else begin
            if (wr_valid && !full) begin
                wptr <= wptr + PW'(1);
            end
            if (wr_valid && full) begin
                ovf <= 1'b1;
            end
            if (rel_valid) begin
                bptr <= bptr + rel_len;
            end
        end
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full) |=> (ovf && $stable(wptr)));

    // R9
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));

endmodule

// File: rtl/hrf_scan.sv
// Combinational block evaluator.
// Looks at the first block-size entries past the block start and reports
// either a short block ending at the first status mark, or a full block when
// enough unmarked bytes are held.
// Assumes occ never exceeds DEPTH and the block size never exceeds MAX_BLK.
module hrf_scan
    import hrf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic [PW-1:0]    base,
    input  logic [PW-1:0]    occ,
    input  logic [1:0]       size_code,
    input  logic [DEPTH-1:0] marks,
    output logic             pool_ok,
    output logic             end_ok,
    output logic [PW-1:0]    end_len,
    output logic [PW-1:0]    size_len
);

    logic          hit;
    logic [PW-1:0] off;
    logic [AW-1:0] idx;

    // Find the nearest status mark inside the window.
    always_comb begin
        size_len = PW'(blk_bytes(size_code));
        hit = 1'b0;
        off = '0;
        idx = '0;
        for (int k = MAX_BLK - 1; k >= 0; k--) begin
            idx = base[AW-1:0] + AW'(k);
            if ((PW'(k) < size_len) && (PW'(k) < occ) && marks[idx]) begin
                hit = 1'b1;
                off = PW'(k);
            end
        end
    end

    assign end_ok  = hit;
    assign end_len = off + PW'(1);
    assign pool_ok = !hit && (occ >= size_len);

endmodule

// File: rtl/hrf_ctrl.sv
// Block handshake controller.
// Holds the single pending announcement and its length, the host read offset
// inside the block, and the per-frame byte count.
// Assumes the evaluator outputs are valid every cycle for the current pointers.
module hrf_ctrl
    import hrf_pkg::*;
#(
    parameter int PW    = 7,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pool_ok,
    input  logic             end_ok,
    input  logic [PW-1:0]    end_len,
    input  logic [PW-1:0]    size_len,
    input  logic             rd_en,
    input  logic             rel_cmd,
    output logic             pend,
    output blk_kind_t        kind,
    output logic [PW-1:0]    blen,
    output logic [PW-1:0]    hoff,
    output logic             rel_valid,
    output logic [CNT_W-1:0] byte_cnt
);

    logic          new_frame;
    logic [PW-1:0] next_len;

    assign next_len  = end_ok ? end_len : size_len;
    assign rel_valid = pend && rel_cmd;

    // Announce, hold, read and release a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            kind      <= BLK_POOL;
            blen      <= '0;
            hoff      <= '0;
            byte_cnt  <= '0;
            new_frame <= 1'b1;
        end else if (pend) begin
            if (rel_cmd) begin
                pend <= 1'b0;
                hoff <= '0;
            end else if (rd_en && (hoff < blen)) begin
                hoff <= hoff + PW'(1);
            end
        end else if (end_ok || pool_ok) begin
            pend      <= 1'b1;
            kind      <= end_ok ? BLK_END : BLK_POOL;
            blen      <= next_len;
            byte_cnt  <= (new_frame ? '0 : byte_cnt) + CNT_W'(next_len);
            new_frame <= end_ok;
        end
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !rel_cmd) |=> (pend && $stable(blen) && $stable(kind)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> (!pend && (hoff == '0)));

    // R8
    host_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && rd_en) |=> $stable(hoff));

    // R5
    count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> (byte_cnt >= CNT_W'(blen)));

endmodule

// File: rtl/hdlc_rx_blkfifo.sv
// HDLC receive FIFO with host block access.
// Connects the byte store, the block evaluator and the handshake controller.
// The receiver writes bytes and flags the end-of-frame status byte. The host
// reads announced blocks and releases them.
// Assumes at most one write and one release per cycle.
module hdlc_rx_blkfifo
    import hrf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_is_status,
    input  logic [1:0]       blk_size_sel,
    input  logic             host_rd,
    input  logic             host_release,
    output logic [7:0]       host_data,
    output logic             irq_pool_full,
    output logic             irq_msg_end,
    output logic [CNT_W-1:0] rx_byte_count,
    output logic             overflow
);

    logic [PW-1:0]    base;
    logic [PW-1:0]    occ;
    logic [DEPTH-1:0] marks;
    logic             pool_ok;
    logic             end_ok;
    logic [PW-1:0]    end_len;
    logic [PW-1:0]    size_len;
    logic             pend;
    blk_kind_t        kind;
    logic [PW-1:0]    blen;
    logic [PW-1:0]    hoff;
    logic             rel_valid;

    hrf_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (rx_valid),
        .wr_data  (rx_byte),
        .wr_mark  (rx_is_status),
        .rel_valid(rel_valid),
        .rel_len  (blen),
        .rd_off   (hoff),
        .rd_data  (host_data),
        .base     (base),
        .occ      (occ),
        .marks    (marks),
        .ovf      (overflow)
    );

    hrf_scan #(.DEPTH(DEPTH)) u_scan (
        .base     (base),
        .occ      (occ),
        .size_code(blk_size_sel),
        .marks    (marks),
        .pool_ok  (pool_ok),
        .end_ok   (end_ok),
        .end_len  (end_len),
        .size_len (size_len)
    );

    hrf_ctrl #(.PW(PW), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pool_ok  (pool_ok),
        .end_ok   (end_ok),
        .end_len  (end_len),
        .size_len (size_len),
        .rd_en    (host_rd),
        .rel_cmd  (host_release),
        .pend     (pend),
        .kind     (kind),
        .blen     (blen),
        .hoff     (hoff),
        .rel_valid(rel_valid),
        .byte_cnt (rx_byte_count)
    );

    assign irq_pool_full = pend && (kind == BLK_POOL);
    assign irq_msg_end   = pend && (kind == BLK_END);

    // R4
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_ok |-> (end_len <= size_len));

    // R3
    announce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && pool_ok) |=> irq_pool_full);

endmodule

// File: tb/hdlc_rx_blkfifo_tb.sv
module hdlc_rx_blkfifo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_is_status = 1'b0;
    logic [1:0]  blk_size_sel = 2'b01;
    logic        host_rd = 1'b0;
    logic        host_release = 1'b0;
    logic [7:0]  host_data;
    logic        irq_pool_full;
    logic        irq_msg_end;
    logic [11:0] rx_byte_count;
    logic        overflow;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_rx_blkfifo u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_is_status(rx_is_status), .blk_size_sel(blk_size_sel),
        .host_rd(host_rd), .host_release(host_release), .host_data(host_data),
        .irq_pool_full(irq_pool_full), .irq_msg_end(irq_msg_end),
        .rx_byte_count(rx_byte_count), .overflow(overflow)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic st);
        rx_valid = 1'b1; rx_byte = d; rx_is_status = st;
        cyc();
        rx_valid = 1'b0; rx_is_status = 1'b0;
    endtask

    task automatic rd();
        host_rd = 1'b1; cyc(); host_rd = 1'b0;
    endtask

    task automatic rel();
        host_release = 1'b1; cyc(); host_release = 1'b0;
        cyc();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
    endtask

    // Frame byte i of a frame with L data bytes; index L is the status byte.
    function automatic logic [7:0] fbyte(input int L, input int i);
        return (i < L) ? 8'(L * 7 + i) : 8'(8'hC0 + L);
    endfunction

    task automatic expect_blk(input string req, input bit is_end, input int cnt);
        chk({req, " pool-full flag"}, int'(irq_pool_full), int'(!is_end));
        chk({req, " message-end flag"}, int'(irq_msg_end), int'(is_end));
        chk({req, " byte count"}, int'(rx_byte_count), cnt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        cyc();
        do_reset();
        // R1 reset state
        chk("R1 pool-full", int'(irq_pool_full), 0);
        chk("R1 message-end", int'(irq_msg_end), 0);
        chk("R1 count", int'(rx_byte_count), 0);
        chk("R1 overflow", int'(overflow), 0);

        // R8 reads with nothing pending are ignored
        rd(); rd(); rd();
        push(fbyte(2, 0), 0); push(fbyte(2, 1), 0); push(fbyte(2, 2), 1);
        push(fbyte(1, 0), 0); push(fbyte(1, 1), 1);
        cyc();
        expect_blk("R4 two short frames, first", 1, 3);
        chk("R8 first byte after idle reads", int'(host_data), int'(fbyte(2, 0)));
        rd(); rd(); rd(); rd(); rd();
        chk("R8 reads beyond block ignored", int'(host_data), int'(fbyte(1, 0)));
        rel(); cyc();
        expect_blk("R5 second frame restarts count", 1, 2);
        chk("R8 next block first byte", int'(host_data), int'(fbyte(1, 0)));
        rel(); cyc();
        chk("R7 empty after release", int'(irq_pool_full | irq_msg_end), 0);
        // R7 release with nothing pending has no effect
        rel();
        blk_size_sel = 2'b11;
        push(fbyte(3, 0), 0); push(fbyte(3, 1), 0); push(fbyte(3, 2), 0); push(fbyte(3, 3), 1);
        cyc();
        expect_blk("R7 idle release ignored", 1, 4);
        chk("R7 idle release kept start", int'(host_data), int'(fbyte(3, 0)));
        rel(); cyc();

        // R3 pool-full mid-frame, then R10 write and release in one cycle
        for (int i = 0; i < 4; i++) push(fbyte(9, i), 0);
        cyc();
        expect_blk("R3 mid-frame full block", 0, 4);
        rx_valid = 1'b1; rx_byte = 8'h5A; rx_is_status = 1'b1; host_release = 1'b1;
        cyc();
        rx_valid = 1'b0; rx_is_status = 1'b0; host_release = 1'b0;
        cyc(); cyc();
        expect_blk("R10 write with release", 1, 5);
        chk("R10 status byte read", int'(host_data), 8'h5A);
        rel(); cyc();

        // R10 size change between blocks, R7 partial read then release
        blk_size_sel = 2'b01;
        for (int i = 0; i <= 20; i++) push(fbyte(20, i), i == 20);
        cyc();
        expect_blk("R2 16-byte block", 0, 16);
        rd(); rd();
        chk("R8 third byte", int'(host_data), int'(fbyte(20, 2)));
        blk_size_sel = 2'b11;
        rel(); cyc();
        expect_blk("R10 new size after release", 0, 20);
        chk("R7 unread bytes discarded", int'(host_data), int'(fbyte(20, 16)));
        rel(); cyc();
        expect_blk("R10 tail block", 1, 21);
        rel(); cyc();

        // R2 R3 R4 R5 sweep over every size code and frame lengths 1..40
        for (int code = 0; code < 4; code++) begin
            for (int L = 1; L <= 40; L++) begin
                int consumed;
                int cnt;
                int S;
                blk_size_sel = 2'(code);
                S = 32 >> code;
                for (int i = 0; i <= L; i++) push(fbyte(L, i), i == L);
                cyc();
                consumed = 0;
                cnt = 0;
                while (consumed < L + 1) begin
                    int rem;
                    int len;
                    bit is_end;
                    rem = L + 1 - consumed;
                    is_end = (rem <= S);
                    len = is_end ? rem : S;
                    cnt += len;
                    expect_blk(is_end ? "R4 sweep block" : "R3 sweep block", is_end, cnt);
                    for (int j = 0; j < len; j++) begin
                        chk("R2 sweep data", int'(host_data), int'(fbyte(L, consumed + j)));
                        rd();
                    end
                    consumed += len;
                    rel(); cyc();
                end
                chk("R6 nothing left", int'(irq_pool_full | irq_msg_end), 0);
            end
        end

        // R9 overflow, and a full-buffer write in the release cycle is dropped
        do_reset();
        blk_size_sel = 2'b00;
        for (int i = 0; i < 64; i++) push(8'(i), 0);
        cyc();
        chk("R9 no overflow at 64", int'(overflow), 0);
        expect_blk("R9 full block", 0, 32);
        push(8'hEE, 1);
        chk("R9 overflow set", int'(overflow), 1);
        rx_valid = 1'b1; rx_byte = 8'hEF; rx_is_status = 1'b1; host_release = 1'b1;
        cyc();
        rx_valid = 1'b0; rx_is_status = 1'b0; host_release = 1'b0;
        cyc(); cyc();
        expect_blk("R9 second block", 0, 64);
        chk("R9 second block data", int'(host_data), 32);
        rel(); cyc();
        chk("R9 dropped writes absent", int'(irq_pool_full | irq_msg_end), 0);
        chk("R9 overflow sticky", int'(overflow), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule